// File: doc/BRIEF.md
# Integer Reservation Station Pool

This block holds a small pool of waiting integer operations for an out-of-order core. The issue stage presents one operation per cycle. Each of its two source operands comes either as a finished value or as the reorder-buffer slot number of the instruction that will produce it. The issue stage also supplies the reorder-buffer slot that will receive the operation's result. An operation is accepted only while `iss_ready` shows a free entry. When the pool is full, the issue stage must hold the operation and retry it later.

Every cycle, each pending operand compares its recorded producer tag against the result broadcast bus. On a match it copies the broadcast value. A broadcast that lands in the same cycle as the issue of a waiting consumer is forwarded straight into the new entry. An entry becomes eligible once its operands are present. An ordinary operation needs both operands. A store needs only its base operand, because this step only computes the store's address. The store's data operand then travels with the dispatch as a tag, or as a value if one has arrived.

When several entries are eligible, the one allocated earliest is sent to the single-cycle execution port, one per cycle, through registered outputs. Its entry is released at the same edge. A flush empties the whole pool in one cycle.

Top module: `rs_pool`

## Requirements
- R1: After reset or a flush, the pool holds no entries. `iss_ready` is 1 and `dsp_valid` is 0, and a later broadcast of a tag recorded before the flush produces no dispatch.
- R2: `iss_ready` is 0 exactly when all N_ENT entries are occupied. An issue request made while `iss_ready` is 0 has no effect.
- R3: An operation issued with both operands ready appears at the dispatch port with its operation code and operand values unchanged. `dsp_valid` rises one clock after the allocation edge.
- R4: A pending operand captures `cdb_val` at an edge where `cdb_valid` is 1 and `cdb_tag` equals its recorded tag. A broadcast with any other tag leaves it pending.
- R5: A broadcast present at the same edge where an operation waiting on that tag is allocated is captured into the new entry. That operation then dispatches at the next edge.
- R6: A non-store operation (`iss_store`=0) does not dispatch while either operand is pending.
- R7: A store (`iss_store`=1) dispatches once its base operand (source A) is present. If the data operand (source B) is still pending, it is sent out with `dsp_b_rdy`=0 and `dsp_b_tag` holding its producer tag.
- R8: Among eligible entries, the earliest allocated dispatches first, one per cycle, whatever the entry index.
- R9: A dispatched entry is released at its dispatch edge. Each accepted operation produces exactly one `dsp_valid` pulse.
- R10: `dsp_dst` carries the destination reorder-buffer tag given at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard every entry and any pending dispatch |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A free entry exists |
| iss_op | input | OP_W | Operation code |
| iss_store | input | 1 | Operation is a store |
| iss_a_rdy | input | 1 | Source A carries a value |
| iss_a_val | input | XLEN | Source A value |
| iss_a_tag | input | TAG_W | Source A producer tag |
| iss_b_rdy | input | 1 | Source B carries a value |
| iss_b_val | input | XLEN | Source B value |
| iss_b_tag | input | TAG_W | Source B producer tag |
| iss_dst | input | TAG_W | Destination reorder-buffer tag |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of broadcast result |
| cdb_val | input | XLEN | Broadcast result value |
| dsp_valid | output | 1 | Dispatch valid (registered) |
| dsp_op | output | OP_W | Dispatched operation code |
| dsp_store | output | 1 | Dispatched operation is a store |
| dsp_a_val | output | XLEN | Source A value |
| dsp_b_rdy | output | 1 | Source B value present |
| dsp_b_val | output | XLEN | Source B value |
| dsp_b_tag | output | TAG_W | Source B producer tag if still pending |
| dsp_dst | output | TAG_W | Destination tag |

## Verification
A lost wakeup shows as an operation that never reaches the dispatch port. A wrong capture shows as a wrong operand value on the next dispatch pulse. Both appear two edges after the broadcast. A corrupted age record shows as a permuted dispatch order, and the bench exposes it by refilling freed low-index entries behind older high-index ones. A free-list error shows either as `iss_ready` staying high with the pool full or as a dropped operation, visible on the first issue after the pool fills.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int XLEN  = 32;
  localparam int TAG_W = 4;
  localparam int OP_W  = 4;

  typedef struct packed {
    logic             rdy;
    logic [TAG_W-1:0] tag;
    logic [XLEN-1:0]  val;
  } opnd_t;

  function automatic opnd_t snoop(input opnd_t o, input logic bv,
                                  input logic [TAG_W-1:0] bt,
                                  input logic [XLEN-1:0] bval);
    opnd_t r;
    r = o;
    if (!o.rdy && bv && (bt == o.tag)) begin
      r.rdy = 1'b1;
      r.val = bval;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] busy,
  output logic [N-1:0] pick,
  output logic         any
);
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i] && !any) begin
        pick[i] = 1'b1;
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // older[i][j] = 1 when entry i was allocated before entry j
  logic [N-1:0] older [N];

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      always_ff @(posedge clk) begin
        if (rst)
          older[i][j] <= 1'b0;
        else if (alloc[j])
          older[i][j] <= (i != j);
        else if (alloc[i])
          older[i][j] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i && req[j] && older[j][i]) blk = 1'b1;
      grant[i] = req[i] && !blk;
    end
  end

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R8
  grant_when_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (grant != '0));
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             alloc,
  input  logic             clear,
  input  logic [OP_W-1:0]  iss_op,
  input  logic             iss_store,
  input  opnd_t            iss_a,
  input  opnd_t            iss_b,
  input  logic [TAG_W-1:0] iss_dst,
  input  logic             cdb_valid,
  input  logic [TAG_W-1:0] cdb_tag,
  input  logic [XLEN-1:0]  cdb_val,
  output logic             valid_o,
  output logic             ready_o,
  output logic [OP_W-1:0]  op_o,
  output logic             store_o,
  output opnd_t            a_o,
  output opnd_t            b_o,
  output logic [TAG_W-1:0] dst_o
);
  logic valid_q;

  always_ff @(posedge clk) begin
    if (rst || flush)  valid_q <= 1'b0;
    else if (alloc)    valid_q <= 1'b1;
    else if (clear)    valid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      op_o    <= iss_op;
      store_o <= iss_store;
      dst_o   <= iss_dst;
      a_o     <= snoop(iss_a, cdb_valid, cdb_tag, cdb_val);
      b_o     <= snoop(iss_b, cdb_valid, cdb_tag, cdb_val);
    end else begin
      a_o     <= snoop(a_o, cdb_valid, cdb_tag, cdb_val);
      b_o     <= snoop(b_o, cdb_valid, cdb_tag, cdb_val);
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && a_o.rdy && (store_o || b_o.rdy);

  // R2
  alloc_free_only_chk: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !valid_q);
  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && !alloc) |=> !valid_q);
  // R4
  capture_a_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !alloc && !a_o.rdy && cdb_valid && cdb_tag == a_o.tag)
      |=> (a_o.rdy && a_o.val == $past(cdb_val)));
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int N_ENT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [OP_W-1:0]  iss_op,
  input  logic             iss_store,
  input  logic             iss_a_rdy,
  input  logic [XLEN-1:0]  iss_a_val,
  input  logic [TAG_W-1:0] iss_a_tag,
  input  logic             iss_b_rdy,
  input  logic [XLEN-1:0]  iss_b_val,
  input  logic [TAG_W-1:0] iss_b_tag,
  input  logic [TAG_W-1:0] iss_dst,
  input  logic             cdb_valid,
  input  logic [TAG_W-1:0] cdb_tag,
  input  logic [XLEN-1:0]  cdb_val,
  output logic             dsp_valid,
  output logic [OP_W-1:0]  dsp_op,
  output logic             dsp_store,
  output logic [XLEN-1:0]  dsp_a_val,
  output logic             dsp_b_rdy,
  output logic [XLEN-1:0]  dsp_b_val,
  output logic [TAG_W-1:0] dsp_b_tag,
  output logic [TAG_W-1:0] dsp_dst
);
  logic [N_ENT-1:0] busy, rdy, free_oh, alloc, grant;
  logic             free_any;
  opnd_t            in_a, in_b;
  logic [OP_W-1:0]  e_op    [N_ENT];
  logic             e_store [N_ENT];
  opnd_t            e_a     [N_ENT];
  opnd_t            e_b     [N_ENT];
  logic [TAG_W-1:0] e_dst   [N_ENT];

  assign in_a = '{rdy: iss_a_rdy, tag: iss_a_tag, val: iss_a_val};
  assign in_b = '{rdy: iss_b_rdy, tag: iss_b_tag, val: iss_b_val};

  rs_free_pick #(.N(N_ENT)) u_free (
    .busy(busy), .pick(free_oh), .any(free_any)
  );

  assign iss_ready = free_any;
  assign alloc     = free_oh & {N_ENT{iss_valid && !flush}};

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    rs_slot u_slot (
      .clk(clk), .rst(rst), .flush(flush),
      .alloc(alloc[i]), .clear(grant[i]),
      .iss_op(iss_op), .iss_store(iss_store),
      .iss_a(in_a), .iss_b(in_b), .iss_dst(iss_dst),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
      .valid_o(busy[i]), .ready_o(rdy[i]),
      .op_o(e_op[i]), .store_o(e_store[i]),
      .a_o(e_a[i]), .b_o(e_b[i]), .dst_o(e_dst[i])
    );
  end

  rs_age_pick #(.N(N_ENT)) u_age (
    .clk(clk), .rst(rst), .alloc(alloc), .req(rdy), .grant(grant)
  );

  logic [OP_W-1:0]  sel_op;
  logic             sel_store;
  opnd_t            sel_a, sel_b;
  logic [TAG_W-1:0] sel_dst;

  always_comb begin
    sel_op = '0; sel_store = 1'b0; sel_a = '0; sel_b = '0; sel_dst = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (grant[i]) begin
        sel_op    = e_op[i];
        sel_store = e_store[i];
        sel_a     = e_a[i];
        sel_b     = e_b[i];
        sel_dst   = e_dst[i];
      end
    end
  end

  logic b_hit;
  assign b_hit = !sel_b.rdy && cdb_valid && (cdb_tag == sel_b.tag);

  always_ff @(posedge clk) begin
    if (rst || flush) dsp_valid <= 1'b0;
    else              dsp_valid <= (grant != '0);
  end

  always_ff @(posedge clk) begin
    if (grant != '0) begin
      dsp_op    <= sel_op;
      dsp_store <= sel_store;
      dsp_a_val <= sel_a.val;
      dsp_b_rdy <= sel_b.rdy || b_hit;
      dsp_b_val <= b_hit ? cdb_val : sel_b.val;
      dsp_b_tag <= sel_b.tag;
      dsp_dst   <= sel_dst;
    end
  end

  // R6
  both_opnd_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !sel_store) |-> (sel_a.rdy && sel_b.rdy));
  // R7
  base_opnd_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> sel_a.rdy);
  // R3
  dispatch_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !flush) |=> dsp_valid);
  // R1
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (busy == '0 && !dsp_valid));
endmodule

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
  import rs_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic iss_valid = 1'b0, iss_ready, iss_store = 1'b0;
  logic [OP_W-1:0] iss_op = '0;
  logic iss_a_rdy = 1'b0, iss_b_rdy = 1'b0;
  logic [XLEN-1:0] iss_a_val = '0, iss_b_val = '0;
  logic [TAG_W-1:0] iss_a_tag = '0, iss_b_tag = '0, iss_dst = '0;
  logic cdb_valid = 1'b0;
  logic [TAG_W-1:0] cdb_tag = '0;
  logic [XLEN-1:0] cdb_val = '0;
  logic dsp_valid, dsp_store, dsp_b_rdy;
  logic [OP_W-1:0] dsp_op;
  logic [XLEN-1:0] dsp_a_val, dsp_b_val;
  logic [TAG_W-1:0] dsp_b_tag, dsp_dst;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_pool #(.N_ENT(N)) dut (
    .clk(clk), .rst(rst), .flush(flush),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_store(iss_store),
    .iss_a_rdy(iss_a_rdy), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
    .iss_b_rdy(iss_b_rdy), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
    .iss_dst(iss_dst),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
    .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_store(dsp_store),
    .dsp_a_val(dsp_a_val), .dsp_b_rdy(dsp_b_rdy), .dsp_b_val(dsp_b_val),
    .dsp_b_tag(dsp_b_tag), .dsp_dst(dsp_dst)
  );

  // {op, store, a value, b value, dst}
  localparam logic [72:0] VEC [4] = '{
    {4'h1, 1'b0, 32'h0000_0001, 32'h0000_0002, 4'h3},
    {4'h7, 1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 4'hF},
    {4'hA, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 4'h0},
    {4'h0, 1'b0, 32'h0000_0000, 32'h5555_AAAA, 4'h8}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [OP_W-1:0] op, input logic st,
                       input logic ar, input logic [XLEN-1:0] av, input logic [TAG_W-1:0] at,
                       input logic br, input logic [XLEN-1:0] bv, input logic [TAG_W-1:0] bt,
                       input logic [TAG_W-1:0] dst);
    iss_op = op; iss_store = st;
    iss_a_rdy = ar; iss_a_val = av; iss_a_tag = at;
    iss_b_rdy = br; iss_b_val = bv; iss_b_tag = bt;
    iss_dst = dst; iss_valid = 1'b1;
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TAG_W-1:0] t, input logic [XLEN-1:0] v);
    cdb_valid = 1'b1; cdb_tag = t; cdb_val = v;
    tick();
    cdb_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 reset iss_ready", 64'(iss_ready), 64'd1);
    chk("R1 reset dsp_valid", 64'(dsp_valid), 64'd0);

    // R3 / R10 vector walk
    for (int v = 0; v < 4; v++) begin
      logic [72:0] e;
      e = VEC[v];
      issue(e[72:69], e[68], 1'b1, e[67:36], '0, 1'b1, e[35:4], '0, e[3:0]);
      chk("R3 no dispatch at alloc edge", 64'(dsp_valid), 64'd0);
      tick();
      chk("R3 dsp_valid", 64'(dsp_valid), 64'd1);
      chk("R3 op", 64'(dsp_op), 64'(e[72:69]));
      chk("R3 store", 64'(dsp_store), 64'(e[68]));
      chk("R3 a", 64'(dsp_a_val), 64'(e[67:36]));
      chk("R3 b", 64'(dsp_b_val), 64'(e[35:4]));
      chk("R10 dst", 64'(dsp_dst), 64'(e[3:0]));
      tick();
      chk("R9 single pulse", 64'(dsp_valid), 64'd0);
    end

    // R4 wakeup, R6 waits for pending A
    issue(4'h2, 1'b0, 1'b0, '0, 4'd5, 1'b1, 32'h11, '0, 4'd2);
    tick();
    chk("R6 waits for A", 64'(dsp_valid), 64'd0);
    bcast(4'd9, 32'hDEAD);
    tick();
    chk("R4 mismatch ignored", 64'(dsp_valid), 64'd0);
    bcast(4'd5, 32'hCAFE);
    chk("R4 captured, not yet out", 64'(dsp_valid), 64'd0);
    tick();
    chk("R4 dispatch after wakeup", 64'(dsp_valid), 64'd1);
    chk("R4 captured value", 64'(dsp_a_val), 64'h0000_CAFE);
    chk("R10 dst after wakeup", 64'(dsp_dst), 64'd2);
    tick();

    // R6 pending B on non-store, then R1 flush
    issue(4'h3, 1'b0, 1'b1, 32'h5, '0, 1'b0, '0, 4'd3, 4'd4);
    tick(); tick();
    chk("R6 waits for B", 64'(dsp_valid), 64'd0);
    flush = 1'b1; tick(); flush = 1'b0;
    chk("R1 flush iss_ready", 64'(iss_ready), 64'd1);
    bcast(4'd3, 32'h77);
    tick(); tick();
    chk("R1 flushed entry silent", 64'(dsp_valid), 64'd0);

    // R5 same-cycle forward
    cdb_valid = 1'b1; cdb_tag = 4'd4; cdb_val = 32'h1234;
    issue(4'h4, 1'b0, 1'b0, '0, 4'd4, 1'b1, 32'h9, '0, 4'd6);
    cdb_valid = 1'b0;
    tick();
    chk("R5 forward dispatch", 64'(dsp_valid), 64'd1);
    chk("R5 forward value", 64'(dsp_a_val), 64'h1234);
    tick();

    // R7 store with pending data
    issue(4'h5, 1'b1, 1'b1, 32'h100, '0, 1'b0, '0, 4'd6, 4'd7);
    tick();
    chk("R7 store dispatch", 64'(dsp_valid), 64'd1);
    chk("R7 store flag", 64'(dsp_store), 64'd1);
    chk("R7 b pending", 64'(dsp_b_rdy), 64'd0);
    chk("R7 b tag", 64'(dsp_b_tag), 64'd6);
    chk("R7 base", 64'(dsp_a_val), 64'h100);
    tick();

    // R2 fill the pool
    issue(4'h1, 1'b0, 1'b0, '0, 4'd1, 1'b1, '0, '0, 4'd10);
    issue(4'h1, 1'b0, 1'b0, '0, 4'd1, 1'b1, '0, '0, 4'd11);
    issue(4'h1, 1'b0, 1'b0, '0, 4'd8, 1'b1, '0, '0, 4'd12);
    issue(4'h1, 1'b0, 1'b0, '0, 4'd8, 1'b1, '0, '0, 4'd13);
    chk("R2 full iss_ready", 64'(iss_ready), 64'd0);
    issue(4'h9, 1'b0, 1'b1, 32'h1, '0, 1'b1, 32'h2, '0, 4'd9);
    tick();
    chk("R2 issue while full ignored", 64'(dsp_valid), 64'd0);

    // R8 age order across refilled low slots
    bcast(4'd1, 32'hA1);
    tick();
    chk("R8 first", 64'(dsp_dst), 64'd10);
    tick();
    chk("R8 second", 64'(dsp_dst), 64'd11);
    chk("R8 second valid", 64'(dsp_valid), 64'd1);
    tick();
    chk("R9 drained", 64'(dsp_valid), 64'd0);
    issue(4'h1, 1'b0, 1'b0, '0, 4'd8, 1'b1, '0, '0, 4'd14);
    issue(4'h1, 1'b0, 1'b0, '0, 4'd8, 1'b1, '0, '0, 4'd15);
    bcast(4'd8, 32'hB8);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R8 order valid", 64'(dsp_valid), 64'd1);
      chk("R8 order dst", 64'(dsp_dst), 64'(12 + k));
      chk("R4 broadcast value", 64'(dsp_a_val), 64'hB8);
    end
    tick();
    chk("R9 no repeat", 64'(dsp_valid), 64'd0);
    chk("R2 pool empty again", 64'(iss_ready), 64'd1);

    finish_run();
  end
endmodule